// File: doc/BRIEF.md
# CAN Transmit Buffer Access Control

This block owns the single outgoing message buffer of a CAN controller. It sits between the CPU and the frame transmitter and decides who may touch the buffer. The buffer holds two identifier/control bytes and up to eight data bytes. While the CPU has the buffer, it fills it byte by byte through a write port. A transmission request then locks the buffer and hands it to the transmitter. The buffer stays locked until the frame goes out or the request is withdrawn.

The CPU sees two status bits. The access bit is high when the buffer is released and writable. The completion bit is high once the last requested frame has been sent. The transmitter receives a request line and the full buffer contents. It reports back with three one-cycle strobes: frame started on the bus, frame sent successfully, and frame lost. A frame can be lost through lost arbitration or an error. An abort issued before the frame starts releases the buffer at once. An abort issued while a frame is on the bus cannot cut that frame short, so the buffer is released only when the frame ends.

Writes made while the buffer is locked are dropped without any error indication. A request that is aborted before it ever went out leaves the completion bit low.

Top module: `can_txbuf_ctrl`

## Requirements
- R1: After reset, `tbuf_access` is 1, `tx_complete` is 1, `tx_request` is 0 and every buffer byte is 0.
- R2: A write with `tbuf_access`=1 and index i in 0..9 stores the byte in `buf_bytes[8*i+7:8*i]`. The new value is visible after the clock edge that takes the write.
- R3: A write while `tbuf_access`=0 changes no buffer byte and raises no indication.
- R4: A write with index 10..15 changes no buffer byte.
- R5: `cmd_tx_req` with `tbuf_access`=1 sets `tbuf_access`=0, `tx_complete`=0 and `tx_request`=1 one cycle later. `cmd_tx_req` while the buffer is locked is ignored.
- R6: `tx_frame_start` while a request is waiting moves the request to the on-bus phase. `tx_done_ok` in the on-bus phase sets `tx_complete`=1, `tbuf_access`=1 and `tx_request`=0 one cycle later.
- R7: `cmd_abort` while a request waits for its frame to start sets `tbuf_access`=1 and leaves `tx_complete`=0 one cycle later. This abort takes priority over a `tx_frame_start` in the same cycle.
- R8: `cmd_abort` during the on-bus phase drops `tx_request` and keeps the buffer locked until the frame ends. The frame then ends in one of two ways: `tx_done_ok` releases the buffer with `tx_complete`=1, and `tx_lost` releases it with `tx_complete`=0.
- R9: `tx_lost` in the on-bus phase without a pending abort returns the request to waiting. The buffer stays locked and `tx_request` stays 1.
- R10: `cmd_abort` while `tbuf_access`=1 changes neither status bit. A completed frame keeps `tx_complete`=1.
- R11: `tx_done_ok` takes priority over `tx_lost` and `cmd_abort` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU byte-write strobe |
| cpu_wr_idx | input | 4 | Byte index of the write |
| cpu_wr_data | input | 8 | Byte to write |
| cmd_tx_req | input | 1 | Transmission request command strobe |
| cmd_abort | input | 1 | Abort command strobe |
| tx_frame_start | input | 1 | Transmitter: frame has started on the bus |
| tx_done_ok | input | 1 | Transmitter: frame sent successfully |
| tx_lost | input | 1 | Transmitter: frame lost (arbitration or error) |
| tbuf_access | output | 1 | 1 = buffer released to the CPU, 0 = locked |
| tx_complete | output | 1 | 1 = last requested frame was sent |
| tx_request | output | 1 | Buffer content is waiting for or on the bus |
| buf_bytes | output | 80 | Buffer contents, byte i at bits 8*i+7:8*i |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. A stored byte appears on `buf_bytes`, and both status bits and the request line change, after the edge that samples the strobe. The bench applies each set of inputs just after a rising edge, waits for the next rising edge, and compares every output a moment later against its own model of the state. A mismatch therefore points at the single cycle whose inputs caused it. Same-cycle combinations of strobes are resolved by the priorities in the requirements, and the random mix deliberately produces such collisions.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;

    localparam int BYTE_W    = 8;
    localparam int MSG_BYTES = 10;
    localparam int IDX_W     = 4;

    // Ownership / progress of the single transmit buffer
    typedef enum logic [1:0] {
        TXS_FREE   = 2'd0,  // CPU owns the buffer
        TXS_QUEUED = 2'd1,  // locked, waiting for the frame to start
        TXS_ON_BUS = 2'd2,  // frame in flight
        TXS_CANCEL = 2'd3   // abort asked during flight, waiting for frame end
    } txs_e;

    typedef struct packed {
        logic req;
        logic abort;
        logic started;
        logic sent_ok;
        logic lost;
    } tx_evt_t;

    typedef struct packed {
        txs_e st;
        logic complete;
    } tx_stat_t;

    localparam tx_stat_t TX_STAT_RESET = '{st: TXS_FREE, complete: 1'b1};

    function automatic logic idx_in_range(input logic [IDX_W-1:0] idx, input int n);
        return int'(idx) < n;
    endfunction

    function automatic tx_stat_t tx_next(input tx_stat_t cur, input tx_evt_t ev);
        tx_stat_t nx;
        nx = cur;
        unique case (cur.st)
            TXS_FREE: begin
                if (ev.req) begin
                    nx.st       = TXS_QUEUED;
                    nx.complete = 1'b0;
                end
            end
            TXS_QUEUED: begin
                if (ev.abort)        nx.st = TXS_FREE;
                else if (ev.started) nx.st = TXS_ON_BUS;
            end
            TXS_ON_BUS: begin
                if (ev.sent_ok) begin
                    nx.st       = TXS_FREE;
                    nx.complete = 1'b1;
                end else if (ev.lost) begin
                    nx.st = TXS_QUEUED;
                end else if (ev.abort) begin
                    nx.st = TXS_CANCEL;
                end
            end
            TXS_CANCEL: begin
                if (ev.sent_ok) begin
                    nx.st       = TXS_FREE;
                    nx.complete = 1'b1;
                end else if (ev.lost) begin
                    nx.st = TXS_FREE;
                end
            end
            default: nx = TX_STAT_RESET;
        endcase
        return nx;
    endfunction

    function automatic logic st_released(input txs_e s);
        return s == TXS_FREE;
    endfunction

    function automatic logic st_requesting(input txs_e s);
        return (s == TXS_QUEUED) || (s == TXS_ON_BUS);
    endfunction

endpackage

// File: rtl/txbuf_store.sv
module txbuf_store
    import can_txbuf_pkg::*;
#(
    parameter int BW    = BYTE_W,
    parameter int NB    = MSG_BYTES,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ok,
    input  logic [IW-1:0]    wr_idx,
    input  logic [BW-1:0]    wr_data,
    output logic [NB*BW-1:0] contents
);
    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [BW-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= '0;
            else if (wr_ok && (wr_idx == IW'(g)))
                byte_q <= wr_data;
        end
        assign contents[g*BW +: BW] = byte_q;
    end
endmodule

// File: rtl/txbuf_fsm.sv
module txbuf_fsm
    import can_txbuf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tx_evt_t  evt,
    output tx_stat_t stat
);
    tx_stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= TX_STAT_RESET;
        else     stat_q <= tx_next(stat_q, evt);
    end

    assign stat = stat_q;
endmodule

// File: rtl/can_txbuf_ctrl.sv
module can_txbuf_ctrl
    import can_txbuf_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NB = MSG_BYTES,
    parameter int IW = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr_en,
    input  logic [IW-1:0]    cpu_wr_idx,
    input  logic [BW-1:0]    cpu_wr_data,
    input  logic             cmd_tx_req,
    input  logic             cmd_abort,
    input  logic             tx_frame_start,
    input  logic             tx_done_ok,
    input  logic             tx_lost,
    output logic             tbuf_access,
    output logic             tx_complete,
    output logic             tx_request,
    output logic [NB*BW-1:0] buf_bytes
);
    localparam int BUF_W = NB * BW;

    tx_evt_t  evt;
    tx_stat_t stat;
    txs_e     fsm_state;
    logic     wr_ok;

    assign evt = '{req: cmd_tx_req, abort: cmd_abort, started: tx_frame_start,
                   sent_ok: tx_done_ok, lost: tx_lost};

    txbuf_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .stat (stat)
    );

    assign fsm_state = stat.st;

    // Writes land only while the CPU owns the buffer and the index exists
    assign wr_ok = cpu_wr_en && st_released(fsm_state) && idx_in_range(cpu_wr_idx, NB);

    txbuf_store #(.BW(BW), .NB(NB), .IW(IW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (wr_ok),
        .wr_idx   (cpu_wr_idx),
        .wr_data  (cpu_wr_data),
        .contents (buf_bytes)
    );

    assign tbuf_access = st_released(fsm_state);
    assign tx_complete = stat.complete;
    assign tx_request  = st_requesting(fsm_state);

    logic [BUF_W-1:0] unused_w;
    assign unused_w = buf_bytes;
endmodule

// File: rtl/can_txbuf_ctrl_chk.sv
module can_txbuf_ctrl_chk
    import can_txbuf_pkg::*;
#(
    parameter int BUF_W = 80
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_wr_en,
    input logic             cmd_tx_req,
    input logic             cmd_abort,
    input logic             tx_done_ok,
    input logic             tx_lost,
    input logic             tbuf_access,
    input logic             tx_complete,
    input logic             tx_request,
    input logic [BUF_W-1:0] buf_bytes,
    input txs_e             fsm_state
);
    assert_locked_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_en && !tbuf_access) |=> $stable(buf_bytes));

    assert_request_locks_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_tx_req && tbuf_access) |=> (!tbuf_access && !tx_complete && tx_request));

    assert_locked_incomplete_R5: assert property (@(posedge clk) disable iff (rst)
        !tbuf_access |-> !tx_complete);

    assert_sent_releases_R6: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == TXS_ON_BUS && tx_done_ok) |=> (tbuf_access && tx_complete && !tx_request));

    assert_abort_queued_R7: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == TXS_QUEUED && cmd_abort) |=> (tbuf_access && !tx_complete));

    assert_cancel_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == TXS_CANCEL && !tx_done_ok && !tx_lost) |=> (!tbuf_access && !tx_request));

    assert_cancel_lost_R8: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == TXS_CANCEL && !tx_done_ok && tx_lost) |=> (tbuf_access && !tx_complete));

    assert_idle_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (tbuf_access && cmd_abort && !cmd_tx_req) |=> (tbuf_access && $stable(tx_complete)));
endmodule

bind can_txbuf_ctrl can_txbuf_ctrl_chk #(.BUF_W(BUF_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_wr_en   (cpu_wr_en),
    .cmd_tx_req  (cmd_tx_req),
    .cmd_abort   (cmd_abort),
    .tx_done_ok  (tx_done_ok),
    .tx_lost     (tx_lost),
    .tbuf_access (tbuf_access),
    .tx_complete (tx_complete),
    .tx_request  (tx_request),
    .buf_bytes   (buf_bytes),
    .fsm_state   (fsm_state)
);

// File: tb/test_can_txbuf_ctrl.sv
`timescale 1ns/1ps
module test_can_txbuf_ctrl;
    localparam int NB = 10;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_wr_en = 1'b0;
    logic [3:0] cpu_wr_idx = '0;
    logic [7:0] cpu_wr_data = '0;
    logic cmd_tx_req = 1'b0, cmd_abort = 1'b0;
    logic tx_frame_start = 1'b0, tx_done_ok = 1'b0, tx_lost = 1'b0;
    logic tbuf_access, tx_complete, tx_request;
    logic [NB*BW-1:0] buf_bytes;

    always #5 clk = ~clk;

    can_txbuf_ctrl i_can_txbuf_ctrl (
        .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_idx(cpu_wr_idx),
        .cpu_wr_data(cpu_wr_data), .cmd_tx_req(cmd_tx_req), .cmd_abort(cmd_abort),
        .tx_frame_start(tx_frame_start), .tx_done_ok(tx_done_ok), .tx_lost(tx_lost),
        .tbuf_access(tbuf_access), .tx_complete(tx_complete), .tx_request(tx_request),
        .buf_bytes(buf_bytes)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Bench model: 0 free, 1 waiting, 2 on bus, 3 abort pending on bus
    int m_st;
    bit m_cpl;
    logic [7:0] m_mem [NB];

    task automatic chk(input string tag, input string what, input logic [NB*BW-1:0] act,
                       input logic [NB*BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NB*BW-1:0] exp_buf();
        logic [NB*BW-1:0] v;
        for (int i = 0; i < NB; i++) v[i*BW +: BW] = m_mem[i];
        return v;
    endfunction

    function automatic string pick_tag();
        if (m_st == 0) begin
            if (cmd_tx_req) return "R5";
            if (cmd_abort) return "R10";
            if (cpu_wr_en && cpu_wr_idx >= 4'(NB)) return "R4";
            return "R2";
        end
        if (m_st == 1) begin
            if (cmd_abort) return "R7";
            if (cpu_wr_en) return "R3";
            if (tx_frame_start) return "R6";
            return "R5";
        end
        if (tx_done_ok && (cmd_abort || tx_lost || m_st == 3)) return "R11";
        if (tx_done_ok) return "R6";
        if (m_st == 3 || cmd_abort) return "R8";
        if (tx_lost) return "R9";
        return "R3";
    endfunction

    task automatic model_step();
        case (m_st)
            0: begin
                if (cpu_wr_en && cpu_wr_idx < 4'(NB)) m_mem[cpu_wr_idx] = cpu_wr_data;
                if (cmd_tx_req) begin m_st = 1; m_cpl = 1'b0; end
            end
            1: if (cmd_abort) m_st = 0; else if (tx_frame_start) m_st = 2;
            2: if (tx_done_ok) begin m_st = 0; m_cpl = 1'b1; end
               else if (tx_lost) m_st = 1;
               else if (cmd_abort) m_st = 3;
            default: if (tx_done_ok) begin m_st = 0; m_cpl = 1'b1; end
                     else if (tx_lost) m_st = 0;
        endcase
    endtask

    // Inputs are already set; take one edge and compare all outputs
    task automatic cycle();
        string tag;
        tag = pick_tag();
        model_step();
        @(posedge clk);
        #1;
        chk(tag, "access", NB*BW'(tbuf_access), NB*BW'(m_st == 0));
        chk(tag, "complete", NB*BW'(tx_complete), NB*BW'(m_cpl));
        chk(tag, "request", NB*BW'(tx_request), NB*BW'(m_st == 1 || m_st == 2));
        chk(tag, "buffer", buf_bytes, exp_buf());
        cpu_wr_en = 0; cmd_tx_req = 0; cmd_abort = 0;
        tx_frame_start = 0; tx_done_ok = 0; tx_lost = 0;
    endtask

    task automatic wr(input int idx, input int d);
        cpu_wr_en = 1; cpu_wr_idx = 4'(idx); cpu_wr_data = 8'(d);
    endtask

    initial begin
        m_st = 0; m_cpl = 1'b1;
        for (int i = 0; i < NB; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1", "access", NB*BW'(tbuf_access), NB*BW'(1));
        chk("R1", "complete", NB*BW'(tx_complete), NB*BW'(1));
        chk("R1", "request", NB*BW'(tx_request), '0);
        chk("R1", "buffer", buf_bytes, '0);

        // R2 fill, R4 out of range
        for (int i = 0; i < NB; i++) begin wr(i, 8'hA0 + i); cycle(); end
        wr(10, 8'h55); cycle();
        wr(15, 8'h66); cycle();
        // R10 abort while free after reset
        cmd_abort = 1; cycle();
        // R5 request + same-cycle write accepted
        cmd_tx_req = 1; wr(3, 8'h33); cycle();
        // R3 locked write, R5 second request ignored
        wr(0, 8'hFF); cycle();
        cmd_tx_req = 1; cycle();
        // R6 start then success
        tx_frame_start = 1; cycle();
        tx_done_ok = 1; cycle();
        // R10 abort after success leaves complete high
        cmd_abort = 1; cycle();
        // R7 abort before start beats same-cycle start
        cmd_tx_req = 1; cycle();
        cmd_abort = 1; tx_frame_start = 1; cycle();
        // R9 lost without abort then retry
        cmd_tx_req = 1; cycle();
        tx_frame_start = 1; cycle();
        tx_lost = 1; cycle();
        // R8 abort on bus, hold, then lost
        tx_frame_start = 1; cycle();
        cmd_abort = 1; cycle();
        wr(1, 8'h11); cycle();
        tx_lost = 1; cycle();
        // R8 abort on bus then success; R11 done beats abort
        cmd_tx_req = 1; cycle();
        tx_frame_start = 1; cycle();
        cmd_abort = 1; cycle();
        tx_done_ok = 1; cycle();
        cmd_tx_req = 1; cycle();
        tx_frame_start = 1; cycle();
        tx_done_ok = 1; cmd_abort = 1; tx_lost = 1; cycle();

        // Random mix, fixed seed
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            cpu_wr_en      = ($urandom % 2) == 0;
            cpu_wr_idx     = 4'($urandom);
            cpu_wr_data    = 8'($urandom);
            cmd_tx_req     = ($urandom % 4) == 0;
            cmd_abort      = ($urandom % 8) == 0;
            tx_frame_start = ($urandom % 3) == 0;
            tx_done_ok     = ($urandom % 6) == 0;
            tx_lost        = ($urandom % 8) == 0;
            cycle();
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule